// File: doc/BRIEF.md
# I2C Target with Register-Write Port

This block is an I2C target that only receives. It gives an external bus controller write access to an 8-bit register file. SCL and SDA are sampled on the system clock. The block drives the open-drain lines only through pull-low enables. A write lands at an internal register port as a single-cycle strobe that carries the register index and the data byte.

The 7-bit bus address has the fixed upper nibble `0100`. Its lowest three bits come from the `addr_lsb_i` input, which is normally fed from a configuration register. Two write shapes are accepted:

- **Single transfer:** the register index and the data arrive in one transfer.
- **Split transfer:** a repeated start separates the phase that sets the register pointer from the phase that carries the payload. The pointer is kept across the repeated start.

After each data byte the target holds SCL low for a short, fixed number of system clocks. This gives the internal write time to finish.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset and before any bus traffic, `sda_oe_o`, `scl_oe_o` and `reg_we_o` are all low.
- R2: For the sequence start, address byte `{0100, addr_lsb_i, 0}`, index byte, data byte, stop, the block gives exactly one `reg_we_o` pulse one clock wide. The pulse carries `reg_waddr_o` equal to the index byte and `reg_wdata_o` equal to the data byte. It comes after the data byte's eighth bit is sampled and while `sda_oe_o` is still low.
- R3: The block pulls SDA low through the whole ninth SCL clock after each of these bytes: a matching address byte with R/W = 0, an index byte, and every data byte.
- R4: For the sequence start, address, index, repeated start, address, data, stop, the data byte is written to the index set before the repeated start. The second address is not treated as an index.
- R5: If the upper seven bits of the address byte differ from `{0100, addr_lsb_i}`, no byte is acknowledged and no write happens until the next start or stop.
- R6: A change of `addr_lsb_i` changes which address the block answers. The old address is then no longer acknowledged.
- R7: After each acknowledged data byte, `scl_oe_o` is high for exactly `STRETCH_CYC` clocks (default 2), and only while `sda_oe_o` is high. SCL is never held after address or index bytes.
- R8: An address byte with the right address and R/W = 1 is not acknowledged, and no write follows.
- R9: Further data bytes in the same transfer each give one strobe, all to the same held index.
- R10: A start that arrives part-way through a byte restarts address reception, and the transfer that follows completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| addr_lsb_i | input | 3 | Low three bits of the bus address |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| reg_waddr_o | output | 8 | Register index for a write |
| reg_wdata_o | output | 8 | Register data for a write |
| reg_we_o | output | 1 | One-cycle register write strobe |

## Verification
The bench acts as the bus controller on a wired-AND bus model. It drives several transfer shapes and each one separates a different behaviour:

- A single-transfer write and a split write with a repeated start tell apart whether the second address byte is taken as an index or the held pointer is used.
- A wrong address, a read request and a changed low address field show whether address matching and the R/W bit gate the acknowledge.
- A burst of two data bytes shows that the pointer stays fixed within a transfer.
- A start injected three bits into a byte shows that bit counting resynchronizes.
- The length of each SCL hold is measured, and every hold is counted, so stretching after data bytes is told apart from stretching after address or index bytes.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  localparam logic [3:0] DEV_HI = 4'b0100;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_DATA,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_s      = sda_q[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer #(
  parameter int unsigned CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic hold_o
);
  localparam int unsigned CW = (CYC < 1) ? 1 : $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (go_i)             cnt_q <= CW'(CYC);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_regwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        addr_lsb_i,
  output logic              sda_oe_o,
  output logic              stretch_go_o,
  output logic [BYTE_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o
);
  st_e               st_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              in_ack_q, ptr_set_q, rs_data_q;
  logic              active, byte_ok;

  assign active = (st_q == ST_DEV) || (st_q == ST_REG) || (st_q == ST_DATA);

  always_comb begin
    case (st_q)
      ST_DEV:          byte_ok = (sh_q[7:1] == {DEV_HI, addr_lsb_i}) && !sh_q[0];
      ST_REG, ST_DATA: byte_ok = 1'b1;
      default:         byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      bit_q        <= '0;
      sh_q         <= '0;
      ptr_q        <= '0;
      in_ack_q     <= 1'b0;
      ptr_set_q    <= 1'b0;
      rs_data_q    <= 1'b0;
      sda_oe_o     <= 1'b0;
      stretch_go_o <= 1'b0;
      wdata_o      <= '0;
      we_o         <= 1'b0;
    end else begin
      we_o         <= 1'b0;
      stretch_go_o <= 1'b0;
      if (stop_i) begin
        st_q      <= ST_IDLE;
        bit_q     <= '0;
        in_ack_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
        ptr_set_q <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_DEV;
        bit_q     <= '0;
        in_ack_q  <= 1'b0;
        sda_oe_o  <= 1'b0;
        rs_data_q <= ptr_set_q; // repeated start after an index byte: payload follows
        ptr_set_q <= 1'b0;
      end else if (active) begin
        if (scl_rise_i && !in_ack_q && bit_q < 4'd8) begin
          sh_q  <= {sh_q[6:0], sda_i};
          bit_q <= bit_q + 4'd1;
          if (st_q == ST_DATA && bit_q == 4'd7) begin
            we_o    <= 1'b1;
            wdata_o <= {sh_q[6:0], sda_i};
          end
        end
        if (scl_fall_i && bit_q == 4'd8) begin
          if (!in_ack_q) begin
            in_ack_q <= 1'b1;
            sda_oe_o <= byte_ok;
            if (!byte_ok) st_q <= ST_SKIP;
            if (byte_ok && st_q == ST_DATA) stretch_go_o <= 1'b1;
          end else begin
            in_ack_q <= 1'b0;
            sda_oe_o <= 1'b0;
            bit_q    <= '0;
            case (st_q)
              ST_DEV: st_q <= rs_data_q ? ST_DATA : ST_REG;
              ST_REG: begin
                ptr_q     <= sh_q;
                ptr_set_q <= 1'b1;
                st_q      <= ST_DATA;
              end
              default: st_q <= st_q;
            endcase
          end
        end
      end
    end
  end

  assign waddr_o = ptr_q;
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_lsb_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic [7:0] reg_waddr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, stretch_go;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_wr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_i        (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_det),
    .stop_i       (stop_det),
    .addr_lsb_i   (addr_lsb_i),
    .sda_oe_o     (sda_oe_o),
    .stretch_go_o (stretch_go),
    .waddr_o      (reg_waddr_o),
    .wdata_o      (reg_wdata_o),
    .we_o         (reg_we_o)
  );

  i2c_stretch_timer #(.CYC(STRETCH_CYC)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (stretch_go),
    .hold_o (scl_oe_o)
  );
endmodule

// File: rtl/i2c_regwr_slave_chk.sv
module i2c_regwr_slave_chk #(
  parameter int unsigned STRETCH_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic reg_we_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (scl_oe_o) run_q <= run_q + 16'd1;
    else               run_q <= '0;
  end

  assert_we_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_we_before_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !sda_oe_o);

  assert_stretch_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 16'(STRETCH_CYC));

  assert_stretch_in_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> sda_oe_o);
endmodule

bind i2c_regwr_slave i2c_regwr_slave_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .reg_we_o (reg_we_o)
);

// File: tb/i2c_regwr_slave_bench.sv
module i2c_regwr_slave_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 20;
  localparam int  STRETCH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] lsb = 3'd3;
  logic       scl_oe, sda_oe, we;
  logic [7:0] waddr, wdata;
  wire        scl_bus = scl_m & ~scl_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int wr_cnt = 0, runs = 0, run = 0, last_run = 0, bad_order = 0;
  logic [7:0] last_a = '0, last_d = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regwr_slave #(.STRETCH_CYC(STRETCH)) u_i2c_regwr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .addr_lsb_i(lsb), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_waddr_o(waddr), .reg_wdata_o(wdata), .reg_we_o(we));

  always @(negedge clk) begin
    if (we) begin
      wr_cnt++; last_a = waddr; last_d = wdata;
      if (sda_oe) bad_order++;
    end
    if (scl_oe) run++;
    else if (run != 0) begin last_run = run; runs++; run = 0; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic scl_hi();
    scl_m = 1'b1;
    wait_cyc(1);
    while (!scl_bus) wait_cyc(1);
    wait_cyc(HALF);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(HALF);
    scl_hi();
    sda_m = 1'b0; wait_cyc(HALF);
    scl_m = 1'b0; wait_cyc(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(HALF);
    scl_hi();
    sda_m = 1'b1; wait_cyc(HALF);
  endtask

  task automatic bus_bit(input bit b);
    sda_m = b; wait_cyc(HALF);
    scl_hi();
    scl_m = 1'b0;
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    sda_m = 1'b1; wait_cyc(HALF);
    scl_hi();
    ack = !sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic t_reset();
    check(!sda_oe && !scl_oe && !we, "R1", {sda_oe, scl_oe, we}, 0);
  endtask

  task automatic t_normal();
    bit a0, a1, a2;
    int w0 = wr_cnt, r0 = runs;
    bus_start();
    bus_byte(8'h46, a0); bus_byte(8'h3C, a1); bus_byte(8'hA5, a2);
    bus_stop();
    check(a0 && a1 && a2, "R3", {a0, a1, a2}, 3'b111);
    check(wr_cnt == w0 + 1, "R2", wr_cnt - w0, 1);
    check(last_a == 8'h3C && last_d == 8'hA5, "R2", {last_a, last_d}, 16'h3CA5);
    check(bad_order == 0, "R2", bad_order, 0);
    check(runs == r0 + 1, "R7", runs - r0, 1);
    check(last_run == STRETCH, "R7", last_run, STRETCH);
  endtask

  task automatic t_combined();
    bit a0, a1, a2, a3;
    int w0 = wr_cnt, r0 = runs;
    bus_start();
    bus_byte(8'h46, a0); bus_byte(8'h10, a1);
    bus_start();
    bus_byte(8'h46, a2); bus_byte(8'h5A, a3);
    bus_stop();
    check(a0 && a1 && a2 && a3, "R3", {a0, a1, a2, a3}, 4'hF);
    check(wr_cnt == w0 + 1, "R4", wr_cnt - w0, 1);
    check(last_a == 8'h10 && last_d == 8'h5A, "R4", {last_a, last_d}, 16'h105A);
    check(runs == r0 + 1, "R7", runs - r0, 1);
  endtask

  task automatic t_mismatch();
    bit a0, a1;
    int w0 = wr_cnt;
    bus_start();
    bus_byte(8'h48, a0); bus_byte(8'h00, a1);
    bus_stop();
    check(!a0 && !a1, "R5", {a0, a1}, 0);
    check(wr_cnt == w0, "R5", wr_cnt - w0, 0);
  endtask

  task automatic t_lsb();
    bit a0, a1, a2, a3;
    int w0 = wr_cnt;
    lsb = 3'd5;
    wait_cyc(4);
    bus_start();
    bus_byte(8'h4A, a0); bus_byte(8'h07, a1); bus_byte(8'hC3, a2);
    bus_stop();
    check(a0 && wr_cnt == w0 + 1 && last_a == 8'h07 && last_d == 8'hC3, "R6",
          {last_a, last_d}, 16'h07C3);
    bus_start();
    bus_byte(8'h46, a3);
    bus_stop();
    check(!a3, "R6", a3, 0);
    lsb = 3'd3;
    wait_cyc(4);
  endtask

  task automatic t_read_req();
    bit a0;
    int w0 = wr_cnt;
    bus_start();
    bus_byte(8'h47, a0);
    bus_stop();
    check(!a0 && wr_cnt == w0, "R8", {a0, 8'(wr_cnt - w0)}, 0);
  endtask

  task automatic t_burst();
    bit a0, a1, a2, a3;
    int w0 = wr_cnt, r0 = runs;
    bus_start();
    bus_byte(8'h46, a0); bus_byte(8'h20, a1);
    bus_byte(8'h11, a2);
    check(last_a == 8'h20 && last_d == 8'h11, "R9", {last_a, last_d}, 16'h2011);
    bus_byte(8'h22, a3);
    bus_stop();
    check(a2 && a3 && wr_cnt == w0 + 2, "R9", wr_cnt - w0, 2);
    check(last_a == 8'h20 && last_d == 8'h22, "R9", {last_a, last_d}, 16'h2022);
    check(runs == r0 + 2, "R7", runs - r0, 2);
  endtask

  task automatic t_mid_start();
    bit a0, a1, a2;
    int w0 = wr_cnt;
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start();
    bus_byte(8'h46, a0); bus_byte(8'h55, a1); bus_byte(8'h77, a2);
    bus_stop();
    check(a0 && a1 && a2, "R10", {a0, a1, a2}, 3'b111);
    check(wr_cnt == w0 + 1 && last_a == 8'h55 && last_d == 8'h77, "R10",
          {last_a, last_d}, 16'h5577);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_normal();
    t_combined();
    t_mismatch();
    t_lsb();
    t_read_req();
    t_burst();
    t_mid_start();
    wait_cyc(10);
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule